// File: doc/BRIEF.md
# ADC Channel Sequencer Controller

This block steers the input multiplexer of a converter through a fixed table of sixteen channel slots. Slot 0 is the offset measurement and slots 1 and 2 are the two external pins. Slot 3 reads temperature, slots 4 through 8 watch internal supplies and references, and slots 9 through 15 read ground. Software picks a first slot and a last slot, and the sequencer walks upward through that range. Each slot gets a fixed conversion window. At the end of the window the block emits a one-cycle result strobe that carries the slot number and a 12-bit value.

Two run styles are offered. A single pass runs the range once, and the trigger bit then clears itself. A looping run returns to the first slot after the last one and keeps going until software writes the trigger low. The slot being converted when that write arrives still completes and reports its result. The conversion time comes from an internal divide-by-`DIV` tick enable: each window lasts `CONV_TICKS` ticks, which is 320 clock cycles at the defaults. Configuration written during a run is held aside and takes effect at the next trigger.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, the trigger bit and the result strobe are 0, and mux_sel is 0. The stored range is first=0 and last=8, in single-pass mode with the second external input enabled, so a trigger with no configuration write converts slots 0 through 8.
- R2: Each slot conversion ends exactly DIV*CONV_TICKS clock cycles (320 by default) after it begins. res_valid is high for one cycle only.
- R3: Slots are converted in ascending order from first to last. mux_sel shows the slot under conversion, and res_slot carries the number of the slot that produced the result.
- R4: When first equals last, only that single slot is converted.
- R5: When first is greater than last, only the first slot is converted.
- R6: In single-pass mode (mode bit 0), busy and the trigger bit both fall on the same clock edge that delivers the result of the last slot.
- R7: In looping mode (mode bit 1), the slot after the last one is the first one, and conversions continue for as long as the trigger bit stays 1.
- R8: Writing the trigger low in looping mode lets the current slot finish and deliver its result. The block then goes idle with busy=0 and the trigger bit at 0.
- R9: When the second external input (slot 2) is disabled, its result reads 0x000, but the slot still takes the full conversion time.
- R10: ref_2x is 1 while slot 8 is selected. For slots 1 and 2 it follows the range bit latched at the trigger. It is 0 for every other slot.
- R11: Configuration writes made while busy do not change the running sequence. They are applied at the next trigger.
- R12: In single-pass mode, trigger writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_first | input | 4 | First slot of the range |
| cfg_last | input | 4 | Last slot of the range |
| cfg_loop | input | 1 | 0 = single pass, 1 = looping |
| cfg_ext2_en | input | 1 | Slot 2 pin is used as a converter input |
| cfg_ext_rng2x | input | 1 | External pins use the 2x reference range |
| trig_we | input | 1 | Trigger bit write strobe |
| trig_wdata | input | 1 | Value written to the trigger bit |
| conv_data | input | 12 | Raw sample from the conversion engine |
| mux_sel | output | 4 | Slot currently routed to the converter |
| ref_2x | output | 1 | Reference range select for the current slot |
| res_valid | output | 1 | One-cycle result strobe |
| res_slot | output | 4 | Slot number of the result |
| res_data | output | 12 | Result value |
| busy | output | 1 | Sequence in progress |
| trig_bit | output | 1 | Readback of the trigger bit |

## Verification
The hardest case to reach is a stop request in looping mode that arrives partway through a slot after the range has already wrapped. The request must let that slot finish and must not cut the run short or stretch it by a slot. The stimulus sets up a three-slot loop and waits for five results, which puts the run in its second pass. It then writes the trigger low about a hundred cycles into the sixth conversion and checks that exactly six results arrive before busy drops. A configuration write made during an earlier single pass is only checked at the following trigger, because its effect cannot be seen from the ports until then.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int SLOT_COUNT = 16;
    localparam int SLOT_W     = $clog2(SLOT_COUNT);
    localparam int RES_W      = 12;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [RES_W-1:0]  res_t;

    typedef enum logic {
        RUN_ONCE = 1'b0,
        RUN_LOOP = 1'b1
    } run_mode_e;

    typedef struct packed {
        slot_t     first;
        slot_t     last;
        run_mode_e mode;
        logic      ext2_en;
        logic      ext_rng2x;
    } seq_cfg_t;

    typedef struct packed {
        logic  valid;
        slot_t slot;
        res_t  data;
    } result_t;

    localparam slot_t SLOT_EXT_A = slot_t'(1);
    localparam slot_t SLOT_EXT_B = slot_t'(2);
    localparam slot_t SLOT_WIDE  = slot_t'(8);

    localparam seq_cfg_t CFG_RESET = '{
        first:     slot_t'(0),
        last:      slot_t'(8),
        mode:      RUN_ONCE,
        ext2_en:   1'b1,
        ext_rng2x: 1'b0
    };

    // Effective final slot: an inverted range collapses onto the first slot.
    function automatic slot_t eff_last(input seq_cfg_t c);
        return (c.first > c.last) ? c.first : c.last;
    endfunction

    // Reference range per slot: slot 8 is always wide; the external pins follow the range bit.
    function automatic logic slot_ref2x(input slot_t s, input logic rng);
        if (s == SLOT_WIDE)
            return 1'b1;
        if (s == SLOT_EXT_A || s == SLOT_EXT_B)
            return rng;
        return 1'b0;
    endfunction

endpackage

// File: rtl/adcseq_tick.sv
module adcseq_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            div_q <= '0;
        else if (div_q == DW'(DIV - 1))
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = run && (div_q == DW'(DIV - 1));

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = tick && (cnt_q == CW'(TICKS - 1));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(TICKS));

    // R2
    done_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> tick);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int DIV        = 16,
    parameter int CONV_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_first,
    input  logic [SLOT_W-1:0] cfg_last,
    input  logic              cfg_loop,
    input  logic              cfg_ext2_en,
    input  logic              cfg_ext_rng2x,
    input  logic              trig_we,
    input  logic              trig_wdata,
    input  logic [RES_W-1:0]  conv_data,
    output logic [SLOT_W-1:0] mux_sel,
    output logic              ref_2x,
    output logic              res_valid,
    output logic [SLOT_W-1:0] res_slot,
    output logic [RES_W-1:0]  res_data,
    output logic              busy,
    output logic              trig_bit
);

    seq_cfg_t cfg_q;
    seq_cfg_t act_q;
    result_t  res_q;
    slot_t    slot_q;
    logic     busy_q;
    logic     trig_q;

    logic start_go;
    logic tick;
    logic done;
    logic restart;
    logic is_last;
    logic halt;
    res_t sample;

    assign start_go = !busy_q && trig_we && trig_wdata;
    assign restart  = start_go || done;
    assign is_last  = (slot_q == eff_last(act_q));
    assign halt     = done && ((act_q.mode == RUN_ONCE) ? is_last : !trig_q);
    assign sample   = (slot_q == SLOT_EXT_B && !act_q.ext2_en) ? '0 : conv_data;

    adcseq_tick #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (busy_q),
        .restart (restart),
        .tick    (tick)
    );

    adcseq_timer #(.TICKS(CONV_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            act_q  <= CFG_RESET;
            res_q  <= '0;
            slot_q <= '0;
            busy_q <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            res_q.valid <= 1'b0;
            if (cfg_we)
                cfg_q <= '{first: cfg_first, last: cfg_last,
                           mode: run_mode_e'(cfg_loop),
                           ext2_en: cfg_ext2_en, ext_rng2x: cfg_ext_rng2x};
            if (start_go) begin
                act_q  <= cfg_q;
                busy_q <= 1'b1;
                trig_q <= 1'b1;
                slot_q <= cfg_q.first;
            end else if (busy_q) begin
                if (trig_we && act_q.mode == RUN_LOOP)
                    trig_q <= trig_wdata;
                if (done) begin
                    res_q <= '{valid: 1'b1, slot: slot_q, data: sample};
                    if (halt) begin
                        busy_q <= 1'b0;
                        trig_q <= 1'b0;
                    end else begin
                        slot_q <= is_last ? act_q.first : slot_q + 1'b1;
                    end
                end
            end
        end
    end

    assign mux_sel   = slot_q;
    assign ref_2x    = slot_ref2x(slot_q, act_q.ext_rng2x);
    assign res_valid = res_q.valid;
    assign res_slot  = res_q.slot;
    assign res_data  = res_q.data;
    assign busy      = busy_q;
    assign trig_bit  = trig_q;

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R6
    end_with_result_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> res_valid);

    // R3
    result_slot_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_slot == $past(slot_q));

    // R5
    slot_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (slot_q >= act_q.first && slot_q <= eff_last(act_q)));

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !start_go) |=> $stable(act_q));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    localparam int PERIOD = 16 * 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_first = '0;
    logic [3:0]  cfg_last = '0;
    logic        cfg_loop = 1'b0;
    logic        cfg_ext2_en = 1'b1;
    logic        cfg_ext_rng2x = 1'b0;
    logic        trig_we = 1'b0;
    logic        trig_wdata = 1'b0;
    logic [11:0] conv_data = 12'h5a3;
    logic [3:0]  mux_sel;
    logic        ref_2x;
    logic        res_valid;
    logic [3:0]  res_slot;
    logic [11:0] res_data;
    logic        busy;
    logic        trig_bit;

    int vecs = 0;
    int errs = 0;
    int got[$];

    always #2.5 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_first(cfg_first),
        .cfg_last(cfg_last), .cfg_loop(cfg_loop), .cfg_ext2_en(cfg_ext2_en),
        .cfg_ext_rng2x(cfg_ext_rng2x), .trig_we(trig_we), .trig_wdata(trig_wdata),
        .conv_data(conv_data), .mux_sel(mux_sel), .ref_2x(ref_2x),
        .res_valid(res_valid), .res_slot(res_slot), .res_data(res_data),
        .busy(busy), .trig_bit(trig_bit)
    );

    // Behavioural reference model
    int c_first, c_last, c_loop, c_en, c_rng;
    int a_first, a_last, a_loop, a_en, a_rng;
    int m_busy, m_trig, m_slot, m_elapsed, m_valid, m_rslot, m_rdata;

    always @(posedge clk) begin
        int old_trig;
        int last_s;
        if (rst) begin
            c_first = 0; c_last = 8; c_loop = 0; c_en = 1; c_rng = 0;
            a_first = 0; a_last = 8; a_loop = 0; a_en = 1; a_rng = 0;
            m_busy = 0; m_trig = 0; m_slot = 0; m_elapsed = 0;
            m_valid = 0; m_rslot = 0; m_rdata = 0;
        end else begin
            m_valid = 0;
            if (!m_busy) begin
                if (trig_we && trig_wdata) begin
                    a_first = c_first; a_last = c_last; a_loop = c_loop;
                    a_en = c_en; a_rng = c_rng;
                    m_busy = 1; m_trig = 1; m_slot = a_first; m_elapsed = 0;
                end
            end else begin
                old_trig = m_trig;
                if (trig_we && a_loop == 1) m_trig = trig_wdata;
                m_elapsed++;
                if (m_elapsed == PERIOD) begin
                    m_valid = 1;
                    m_rslot = m_slot;
                    m_rdata = (m_slot == 2 && a_en == 0) ? 0 : int'(conv_data);
                    last_s = (a_first > a_last) ? a_first : a_last;
                    if ((a_loop == 0 && m_slot == last_s) || (a_loop == 1 && old_trig == 0)) begin
                        m_busy = 0; m_trig = 0;
                    end else begin
                        m_slot = (m_slot == last_s) ? a_first : m_slot + 1;
                        m_elapsed = 0;
                    end
                end
            end
            if (cfg_we) begin
                c_first = cfg_first; c_last = cfg_last; c_loop = cfg_loop;
                c_en = cfg_ext2_en; c_rng = cfg_ext_rng2x;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        conv_data <= conv_data * 12'd5 + 12'd613;
    end

    always @(negedge clk) begin
        int exp_ref;
        if (!rst) begin
            exp_ref = (m_slot == 8 || ((m_slot == 1 || m_slot == 2) && a_rng == 1)) ? 1 : 0;
            chk(busy == m_busy,          "R6",  "busy",      busy,      m_busy);
            chk(trig_bit == m_trig,      "R6",  "trig_bit",  trig_bit,  m_trig);
            chk(res_valid == m_valid,    "R2",  "res_valid", res_valid, m_valid);
            chk(mux_sel == m_slot,       "R3",  "mux_sel",   mux_sel,   m_slot);
            chk(res_slot == m_rslot,     "R3",  "res_slot",  res_slot,  m_rslot);
            chk(res_data == m_rdata,     "R9",  "res_data",  res_data,  m_rdata);
            chk(ref_2x == exp_ref,       "R10", "ref_2x",    ref_2x,    exp_ref);
            if (res_valid) got.push_back(int'(res_slot));
        end
    end

    task automatic write_cfg(input int f, input int l, input bit lp, input bit en, input bit rg);
        @(negedge clk);
        cfg_we = 1'b1; cfg_first = 4'(f); cfg_last = 4'(l);
        cfg_loop = lp; cfg_ext2_en = en; cfg_ext_rng2x = rg;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_trig(input bit v);
        @(negedge clk);
        trig_we = 1'b1; trig_wdata = v;
        @(negedge clk);
        trig_we = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_results(input int n);
        while (got.size() < n) @(negedge clk);
    endtask

    task automatic expect_seq(input string tag, input int exp[$]);
        chk(got.size() == exp.size(), tag, "result count", got.size(), exp.size());
        foreach (exp[i]) begin
            if (i < got.size())
                chk(got[i] == exp[i], tag, "slot order", got[i], exp[i]);
        end
        got.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0,      "R1", "busy after reset",  busy,      0);
        chk(trig_bit == 1'b0,  "R1", "trig after reset",  trig_bit,  0);
        chk(res_valid == 1'b0, "R1", "valid after reset", res_valid, 0);
        chk(mux_sel == 4'd0,   "R1", "mux after reset",   mux_sel,   0);

        // R1 default range 0..8, single pass (R6)
        write_trig(1'b1);
        wait_idle();
        expect_seq("R1", '{0, 1, 2, 3, 4, 5, 6, 7, 8});
        chk(trig_bit == 1'b0, "R6", "self clear", trig_bit, 0);

        // R9 and R10: slots 1..3, slot 2 disabled, wide range
        write_cfg(1, 3, 1'b0, 1'b0, 1'b1);
        write_trig(1'b1);
        repeat (50) @(negedge clk);
        // R12 trigger low while busy in single pass is ignored
        write_trig(1'b0);
        chk(trig_bit == 1'b1, "R12", "trig held", trig_bit, 1);
        // R11 config write while busy
        write_cfg(9, 9, 1'b0, 1'b1, 1'b0);
        wait_idle();
        expect_seq("R11", '{1, 2, 3});

        // R4 and R11: the config written during the last run applies now
        write_trig(1'b1);
        wait_idle();
        expect_seq("R4", '{9});

        // R5 inverted range
        write_cfg(12, 4, 1'b0, 1'b1, 1'b0);
        write_trig(1'b1);
        wait_idle();
        expect_seq("R5", '{12});

        // R7 and R8 looping run, stop requested mid conversion
        write_cfg(13, 15, 1'b1, 1'b1, 1'b0);
        write_trig(1'b1);
        wait_results(5);
        repeat (100) @(negedge clk);
        write_trig(1'b0);
        chk(busy == 1'b1, "R8", "still busy after stop write", busy, 1);
        wait_idle();
        expect_seq("R7", '{13, 14, 15, 13, 14, 15});
        chk(busy == 1'b0,     "R8", "idle after stop", busy,     0);
        chk(trig_bit == 1'b0, "R8", "trig after stop", trig_bit, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule